// File: doc/BRIEF.md
# Mask-Based Address Relocation Unit

This unit sits between a processor's address bus and memory. Supervisor accesses pass straight through. For a user access, every address bit at or above a programmable split position K is replaced by the matching bit of a relocation base register. The bits below K pass through unchanged. No adder sits anywhere in the path: relocation is a per-bit multiplexer. As a result, each process window is a power-of-two block placed at a physical location aligned to its own size.

The bounds check accepts a user access only when the address bits from K upward are uniform, meaning all zeros or all ones. A process can therefore grow its data upward from address zero and its stack downward from just below the top of the address space. Both ends fold onto the same relocated window. A user access whose upper bits are mixed is not forwarded and raises a one-cycle fault. The unit records the faulting virtual address and mode in a status register, which keeps its contents until software clears it.

The access interface has a valid strobe and no ready. The unit accepts an access on every cycle and applies no back-pressure. The downstream side must take each result in the cycle it is presented. Each result appears one clock after its strobe, as either a valid strobe with a physical address or a fault pulse.

Top module: `relo_unit`

## Requirements
- R1: A supervisor access (`acc_user`=0) yields `out_valid`=1 one cycle later with `out_pa` equal to the virtual address, whatever that address is, and never yields `out_fault`.
- R2: A user access inside the window yields `out_pa` = {base[31:K], va[K-1:0]}, so bits of the relocation base below K have no effect on any result.
- R3: A user access is inside the window when va[31:K] is all zeros or all ones. Otherwise it gives `out_fault`=1 and `out_valid`=0.
- R4: `out_valid` and `out_fault` are registered. They reflect the access strobed one cycle earlier, are never both 1, and are both 0 in the cycle after a cycle with no strobe.
- R5: A configuration write with `cfg_sel`=1 sets K from `cfg_wdata[4:0]`, and a value below 12 is stored as 12. A write with `cfg_sel`=0 sets the relocation base from `cfg_wdata`. After reset, K=12 and the base is 0.
- R6: A configuration write takes effect for accesses from the next cycle on. An access in the same cycle as a write uses the old values.
- R7: When an access faults, the unit captures its virtual address into `flt_va` and its mode into `flt_user`, and sets `flt_held`=1, in the same edge as `out_fault`. Later faults do not overwrite a held record. A write with `cfg_sel`=2 clears it. If a clear and a fault land in the same cycle, the new fault is kept. A write with `cfg_sel`=3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe, accepted every cycle |
| acc_user | input | 1 | 1 = user mode, 0 = supervisor |
| acc_va | input | 32 | Virtual address |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | 0 base, 1 split K, 2 clear fault record, 3 none |
| cfg_wdata | input | 32 | Configuration write data |
| out_valid | output | 1 | Translated access valid |
| out_pa | output | 32 | Physical address, updated on each forwarded access |
| out_fault | output | 1 | One-cycle fault pulse |
| flt_held | output | 1 | A fault record is held |
| flt_va | output | 32 | Virtual address of the recorded fault |
| flt_user | output | 1 | Mode of the recorded fault |

## Verification
The hardest cases sit exactly on the window edges: the last address of the low region, the first address of the high region, and their neighbours one step outside. Their positions move with every value of K. The bench therefore programs each split from 12 to 31 and, for each one, issues those edge addresses and a mixed-pattern address in both modes, comparing every result with arithmetic computed from K. It also places a configuration write in the same cycle as an access, to show that the old setting still applies. Finally, it places a clear in the same cycle as a fault to show which one wins.

// File: rtl/relo_pkg.sv
package relo_pkg;
  typedef enum logic [1:0] {
    SEL_BASE  = 2'd0,
    SEL_SHIFT = 2'd1,
    SEL_CLEAR = 2'd2,
    SEL_NONE  = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/relo_cfg.sv
module relo_cfg
  import relo_pkg::*;
#(
  parameter int AW   = 32,
  parameter int KMIN = 12,
  parameter int KW   = $clog2(AW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [1:0]    sel,
  input  logic [AW-1:0] wdata,
  output logic [AW-1:0] base,
  output logic [KW-1:0] shift,
  output logic          clr
);
  localparam logic [KW-1:0] KMIN_V = KW'(KMIN);

  logic [KW-1:0] shift_req;
  assign shift_req = wdata[KW-1:0];
  assign clr = we && (cfg_sel_e'(sel) == SEL_CLEAR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base  <= '0;
      shift <= KMIN_V;
    end else if (we) begin
      case (cfg_sel_e'(sel))
        SEL_BASE:  base  <= wdata;
        SEL_SHIFT: shift <= (shift_req < KMIN_V) ? KMIN_V : shift_req;
        default:   ;
      endcase
    end
  end

  // R5: split never leaves the legal range
  a_r5_shift_range: assert property (@(posedge clk) disable iff (!rst_n)
    shift >= KMIN_V);
endmodule

// File: rtl/relo_xlat.sv
module relo_xlat #(
  parameter int AW = 32,
  parameter int KW = $clog2(AW)
) (
  input  logic [AW-1:0] va,
  input  logic          user,
  input  logic [AW-1:0] base,
  input  logic [KW-1:0] shift,
  output logic [AW-1:0] pa,
  output logic          in_win
);
  logic [AW-1:0] hi;

  for (genvar i = 0; i < AW; i++) begin : g_bit
    localparam logic [KW-1:0] IDX = KW'(i);
    assign hi[i] = (IDX >= shift);
    assign pa[i] = (user && hi[i]) ? base[i] : va[i];
  end

  logic up_zero, up_one;
  assign up_zero = ~|(va & hi);
  assign up_one  = &(va | ~hi);
  assign in_win  = !user || up_zero || up_one;
endmodule

// File: rtl/relo_flog.sv
module relo_flog #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fault_d,
  input  logic [AW-1:0] va,
  input  logic          user,
  input  logic          clr,
  output logic          held,
  output logic [AW-1:0] rec_va,
  output logic          rec_user
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held     <= 1'b0;
      rec_va   <= '0;
      rec_user <= 1'b0;
    end else if (fault_d && (!held || clr)) begin
      held     <= 1'b1;
      rec_va   <= va;
      rec_user <= user;
    end else if (clr) begin
      held     <= 1'b0;
      rec_va   <= '0;
      rec_user <= 1'b0;
    end
  end

  // R7: a held record is not overwritten until cleared
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    held && !clr |=> held && $stable(rec_va) && $stable(rec_user));
endmodule

// File: rtl/relo_unit.sv
module relo_unit #(
  parameter int AW   = 32,
  parameter int KMIN = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic          acc_user,
  input  logic [AW-1:0] acc_va,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output logic          out_valid,
  output logic [AW-1:0] out_pa,
  output logic          out_fault,
  output logic          flt_held,
  output logic [AW-1:0] flt_va,
  output logic          flt_user
);
  localparam int KW = $clog2(AW);

  logic [AW-1:0] base;
  logic [KW-1:0] shift;
  logic          clr;
  logic [AW-1:0] pa_c;
  logic          in_win;
  logic          fault_d;

  relo_cfg #(.AW(AW), .KMIN(KMIN), .KW(KW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .base(base), .shift(shift), .clr(clr)
  );

  relo_xlat #(.AW(AW), .KW(KW)) u_xlat (
    .va(acc_va), .user(acc_user), .base(base), .shift(shift),
    .pa(pa_c), .in_win(in_win)
  );

  assign fault_d = acc_valid && !in_win;

  relo_flog #(.AW(AW)) u_flog (
    .clk(clk), .rst_n(rst_n), .fault_d(fault_d), .va(acc_va), .user(acc_user),
    .clr(clr), .held(flt_held), .rec_va(flt_va), .rec_user(flt_user)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_fault <= 1'b0;
      out_pa    <= '0;
    end else begin
      out_valid <= acc_valid && in_win;
      out_fault <= fault_d;
      if (acc_valid && in_win) out_pa <= pa_c;
    end
  end

  // R4: outputs are mutually exclusive
  a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_fault));

  // R4: no strobe, no result
  a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !out_valid && !out_fault);

  // R1: supervisor access forwarded unchanged, never faults
  a_r1_sup_pass: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !acc_user |=> out_valid && !out_fault && out_pa == $past(acc_va));

  // R7: every fault pulse leaves a record behind
  a_r7_record: assert property (@(posedge clk) disable iff (!rst_n)
    out_fault |-> flt_held);
endmodule

// File: tb/tb_relo_unit.sv
module tb_relo_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_user = 1'b0;
  logic [31:0] acc_va = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd3;
  logic [31:0] cfg_wdata = '0;
  logic        out_valid, out_fault, flt_held, flt_user;
  logic [31:0] out_pa, flt_va;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  relo_unit dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_user(acc_user),
    .acc_va(acc_va), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .out_valid(out_valid), .out_pa(out_pa), .out_fault(out_fault),
    .flt_held(flt_held), .flt_va(flt_va), .flt_user(flt_user)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_sel = 2'd3;
  endtask

  // drive one access, sample the result one edge later
  task automatic access(input logic [31:0] va, input logic user);
    acc_valid = 1'b1; acc_user = user; acc_va = va;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic check_ref(input logic [31:0] va, input logic user,
                           input int k, input logic [31:0] base);
    logic [31:0] m, e_pa;
    logic ok;
    m    = ~((32'd1 << k) - 32'd1);
    ok   = !user || ((va & m) == 32'd0) || ((va & m) == m);
    e_pa = user ? ((base & m) | (va & ~m)) : va;
    access(va, user);
    if (!user) begin
      chk("R1 valid", {31'd0, out_valid}, 32'd1);
      chk("R1 fault", {31'd0, out_fault}, 32'd0);
      chk("R1 pa", out_pa, va);
    end else begin
      chk("R3 valid", {31'd0, out_valid}, {31'd0, ok});
      chk("R3 fault", {31'd0, out_fault}, {31'd0, !ok});
      if (ok) chk("R2 pa", out_pa, e_pa);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state (R4, R7)
    chk("R4 reset valid", {31'd0, out_valid}, 32'd0);
    chk("R4 reset fault", {31'd0, out_fault}, 32'd0);
    chk("R7 reset held", {31'd0, flt_held}, 32'd0);
    // R5 reset: K=12, base=0
    check_ref(32'h0000_0FFF, 1'b1, 12, 32'd0);
    check_ref(32'h0000_1000, 1'b1, 12, 32'd0);
    check_ref(32'hFFFF_F000, 1'b1, 12, 32'd0);
    // R4: idle cycle gives nothing
    @(negedge clk);
    chk("R4 idle valid", {31'd0, out_valid}, 32'd0);
    chk("R4 idle fault", {31'd0, out_fault}, 32'd0);
    // clear record left by the reset tests
    cfg_write(2'd2, 32'd0);
    chk("R7 cleared", {31'd0, flt_held}, 32'd0);

    // sweep every split (R1, R2, R3)
    for (int k = 12; k < 32; k++) begin
      base = 32'hA5C3_9E71 ^ (32'h1357_9BDF << (k - 12));
      cfg_write(2'd0, base);
      cfg_write(2'd1, k);
      for (int u = 0; u < 2; u++) begin
        logic [31:0] lo_top, hi_bot;
        lo_top = (32'd1 << k) - 32'd1;
        hi_bot = ~lo_top;
        check_ref(32'd0, u[0], k, base);
        check_ref(lo_top, u[0], k, base);
        check_ref(lo_top + 32'd1, u[0], k, base);
        check_ref(hi_bot, u[0], k, base);
        check_ref(hi_bot - 32'd1, u[0], k, base);
        check_ref(32'hFFFF_FFFE, u[0], k, base);
        check_ref(32'hFFFF_FFFF, u[0], k, base);
        check_ref(32'h5555_5555, u[0], k, base);
      end
      cfg_write(2'd2, 32'd0);
    end

    // R5: clamp of a small split
    cfg_write(2'd1, 32'd3);
    check_ref(32'h0000_0FFF, 1'b1, 12, 32'hA5C3_9E71 ^ (32'h1357_9BDF << 19));
    access(32'h0000_1000, 1'b1);
    chk("R5 clamp fault", {31'd0, out_fault}, 32'd1);
    cfg_write(2'd2, 32'd0);

    // R6: write and access in the same cycle use old values
    cfg_write(2'd1, 32'd20);
    cfg_write(2'd0, 32'h0000_0000);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd1; cfg_wdata = 32'd24;
    access(32'h0010_0000, 1'b1);
    cfg_we = 1'b0; cfg_sel = 2'd3;
    chk("R6 old split fault", {31'd0, out_fault}, 32'd1);
    access(32'h0010_0000, 1'b1);
    chk("R6 new split valid", {31'd0, out_valid}, 32'd1);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 32'hFF00_0000;
    access(32'h0000_0123, 1'b1);
    cfg_we = 1'b0; cfg_sel = 2'd3;
    chk("R6 old base pa", out_pa, 32'h0000_0123);
    access(32'h0000_0123, 1'b1);
    chk("R6 new base pa", out_pa, 32'hFF00_0123);

    // R7: capture, hold, clear, same-cycle clear/fault, sel=3 ignored
    cfg_write(2'd2, 32'd0);
    access(32'h0100_0000, 1'b1);
    chk("R7 held", {31'd0, flt_held}, 32'd1);
    chk("R7 va", flt_va, 32'h0100_0000);
    chk("R7 mode", {31'd0, flt_user}, 32'd1);
    access(32'h0200_0000, 1'b1);
    chk("R7 not overwritten", flt_va, 32'h0100_0000);
    cfg_write(2'd3, 32'd0);
    chk("R7 sel3 ignored held", {31'd0, flt_held}, 32'd1);
    access(32'h0000_0123, 1'b1);
    chk("R7 sel3 ignored base", out_pa, 32'hFF00_0123);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd2; cfg_wdata = 32'd0;
    access(32'h0300_0000, 1'b1);
    cfg_we = 1'b0; cfg_sel = 2'd3;
    chk("R7 fault wins over clear", flt_va, 32'h0300_0000);
    chk("R7 still held", {31'd0, flt_held}, 32'd1);
    cfg_write(2'd2, 32'd0);
    chk("R7 clear", {31'd0, flt_held}, 32'd0);
    chk("R7 clear va", flt_va, 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule